// File: doc/BRIEF.md
# Capture Interrupt Flag Controller

This block keeps the interrupt status of an edge-capture timer unit. Three event pulses arrive from the capture logic: a rising-edge capture, a falling-edge capture and a counter wraparound from 0xFFFF to 0x0000. Each pulse latches a sticky flag. A second rising event that arrives while the rising flag is still set latches a separate rising-overflow flag. The whole status can be read back as one 16-bit word.

Software clears flags through a clear-register write strobe. It can raise event flags through a force-register write strobe. A soft-reset input wipes everything. When an event flag whose enable bit is set is pending and the global flag is low, the block sets the global flag and emits a one-cycle interrupt request. While the global flag stays set, no further requests are produced. Clearing the global flag re-arms the block.

Top module: `capture_irq_flags`

## Requirements
- R1: The status word is 16 bits wide. Bit 0 is the global flag, bit 1 the rising flag, bit 2 the falling flag, bit 3 the wrap flag and bit 4 the rising-overflow flag. Bits 15 to 5 always read 0.
- R2: While reset is active, and after it is released, every status bit and the interrupt request read 0.
- R3: A pulse on `riseEvt`, `fallEvt` or `wrapEvt` sets status bit 1, 2 or 3 respectively, visible in the cycle after the pulse.
- R4: A rising event, real or forced, that occurs while status bit 1 is already 1 sets status bit 4. Falling and wrap events never set bit 4.
- R5: A clear write (`clrWrEn` high) with a 1 in bit position n (n from 0 to 4) of `wrData` clears status bit n. Zero bits, and data presented with `clrWrEn` low, change nothing. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A force write (`forceWrEn` high) with a 1 in `wrData` bit 1, 2 or 3 sets that flag exactly as the matching event would. Bits 0, 4 and 15 to 5 of a force write are ignored.
- R7: A cycle with `softReset` high clears all five flags, including the global flag. It takes priority over any set in the same cycle and produces no interrupt request.
- R8: The global flag is set when it is 0 and at least one of flags 1 to 3 is 1 with its enable bit set (`intEnable` bit 0 for rise, bit 1 for fall, bit 2 for wrap). `irqPulse` is high for exactly the one cycle in which the global flag first reads 1. Disabled flags never raise it.
- R9: While the global flag is 1, `irqPulse` stays 0 no matter which events arrive.
- R10: After the global flag is cleared, if an enabled event flag is still 1, the global flag and `irqPulse` come back one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| riseEvt | input | 1 | Rising-edge capture event pulse |
| fallEvt | input | 1 | Falling-edge capture event pulse |
| wrapEvt | input | 1 | Capture counter wraparound pulse |
| intEnable | input | 3 | Interrupt enables: bit 0 rise, bit 1 fall, bit 2 wrap |
| clrWrEn | input | 1 | Write strobe for the clear register |
| forceWrEn | input | 1 | Write strobe for the force register |
| wrData | input | 16 | Write data shared by the clear and force registers |
| softReset | input | 1 | Synchronous wipe of all flags |
| status | output | 16 | Status word (layout in R1) |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The main function is swept over every combination of the three enable bits and the three simultaneous event pulses. The first read shows that each event maps to its own flag position regardless of enables. The second read separates an enabled combination, which must raise the global flag and the request, from one whose flags are all masked. Directed sequences then cover the following cases:
- back-to-back rising events against falling repeats, which tells a true rising overflow from a generic repeat;
- clear and force data patterns with zero bits, ignored positions and a deasserted strobe;
- a clear that collides with an event on the same bit;
- events that arrive while the global flag is held, compared with the re-arm after the global flag is cleared.

// File: rtl/capirq_pkg.sv
package capirq_pkg;

  localparam int STATUS_W  = 16;
  localparam int NUM_FLAGS = 5;
  localparam int NUM_SRC   = 3;

  localparam int BIT_GLOBAL   = 0;
  localparam int BIT_RISE     = 1;
  localparam int BIT_FALL     = 2;
  localparam int BIT_WRAP     = 3;
  localparam int BIT_RISE_OVF = 4;

  // Strobes from control to the flag register: per-bit set and clear
  // requests plus a wipe that overrides both.
  typedef struct packed {
    logic                 wipe;
    logic [NUM_FLAGS-1:0] setMask;
    logic [NUM_FLAGS-1:0] clrMask;
  } flagStrobes_t;

endpackage

// File: rtl/capirq_datapath.sv
module capirq_datapath
  import capirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobes_t         strb,
  output logic [NUM_FLAGS-1:0] flagsQ,
  output logic [STATUS_W-1:0]  statusWord
);

  localparam int PAD_W = STATUS_W - NUM_FLAGS;

  // One sticky cell per flag. Priority: wipe, then set, then clear.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 flagsQ[i] <= 1'b0;
      else if (strb.wipe)        flagsQ[i] <= 1'b0;
      else if (strb.setMask[i])  flagsQ[i] <= 1'b1;
      else if (strb.clrMask[i])  flagsQ[i] <= 1'b0;
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign statusWord = {{PAD_W{1'b0}}, flagsQ};
  end else begin : g_nopad
    assign statusWord = flagsQ[STATUS_W-1:0];
  end

  // A pending set must never be lost to a clear in the same cycle.
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask[BIT_RISE] && strb.clrMask[BIT_RISE] && !strb.wipe)
      |=> statusWord[BIT_RISE]); // R5

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[STATUS_W-1:NUM_FLAGS] == '0); // R1

endmodule

// File: rtl/capirq_ctrl.sv
module capirq_ctrl
  import capirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 riseEvt,
  input  logic                 fallEvt,
  input  logic                 wrapEvt,
  input  logic [NUM_SRC-1:0]   intEnable,
  input  logic                 clrWrEn,
  input  logic                 forceWrEn,
  input  logic [STATUS_W-1:0]  wrData,
  input  logic                 softReset,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  output flagStrobes_t         strb,
  output logic                 irqQ
);

  logic [NUM_FLAGS-1:0] clrBits;
  logic [NUM_FLAGS-1:0] forceBits;
  logic [NUM_SRC-1:0]   srcHit;
  logic [NUM_SRC-1:0]   srcPending;
  logic                 trigger;
  logic                 unusedWrBits;

  assign clrBits   = clrWrEn   ? wrData[NUM_FLAGS-1:0] : '0;
  assign forceBits = forceWrEn ? wrData[NUM_FLAGS-1:0] : '0;
  // Force positions that carry no meaning, plus the upper data bits.
  assign unusedWrBits = ^wrData[STATUS_W-1:NUM_FLAGS]
                      ^ forceBits[BIT_GLOBAL] ^ forceBits[BIT_RISE_OVF];

  // Event sources: real pulse or forced bit, in the order rise, fall, wrap.
  assign srcHit[0] = riseEvt | forceBits[BIT_RISE];
  assign srcHit[1] = fallEvt | forceBits[BIT_FALL];
  assign srcHit[2] = wrapEvt | forceBits[BIT_WRAP];

  // Event flags sit at status bits BIT_RISE onward, in the same order.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcPending[s] = flagsIn[BIT_RISE + s] & intEnable[s];
  end

  assign trigger = !flagsIn[BIT_GLOBAL] && (|srcPending);

  always_comb begin
    strb.wipe    = softReset;
    strb.clrMask = clrBits;
    strb.setMask = '0;
    strb.setMask[BIT_GLOBAL]   = trigger;
    strb.setMask[BIT_RISE]     = srcHit[0];
    strb.setMask[BIT_FALL]     = srcHit[1];
    strb.setMask[BIT_WRAP]     = srcHit[2];
    strb.setMask[BIT_RISE_OVF] = srcHit[0] & flagsIn[BIT_RISE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= trigger & !softReset;
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (riseEvt && !softReset) |=> flagsIn[BIT_RISE]); // R3

  AST_RISE_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (riseEvt && flagsIn[BIT_RISE] && !softReset) |=> flagsIn[BIT_RISE_OVF]); // R4

  AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (flagsIn == '0 && !irqQ)); // R7

  AST_IRQ_ON_GLOBAL_RISE: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> (flagsIn[BIT_GLOBAL] && !$past(flagsIn[BIT_GLOBAL]))); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> !irqQ); // R8

  AST_HOLD_WHILE_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    (flagsIn[BIT_GLOBAL] && $past(flagsIn[BIT_GLOBAL])) |-> !irqQ); // R9

endmodule

// File: rtl/capture_irq_flags.sv
module capture_irq_flags
  import capirq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                riseEvt,
  input  logic                fallEvt,
  input  logic                wrapEvt,
  input  logic [NUM_SRC-1:0]  intEnable,
  input  logic                clrWrEn,
  input  logic                forceWrEn,
  input  logic [STATUS_W-1:0] wrData,
  input  logic                softReset,
  output logic [STATUS_W-1:0] status,
  output logic                irqPulse
);

  flagStrobes_t         strb;
  logic [NUM_FLAGS-1:0] flagsQ;

  capirq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .riseEvt   (riseEvt),
    .fallEvt   (fallEvt),
    .wrapEvt   (wrapEvt),
    .intEnable (intEnable),
    .clrWrEn   (clrWrEn),
    .forceWrEn (forceWrEn),
    .wrData    (wrData),
    .softReset (softReset),
    .flagsIn   (flagsQ),
    .strb      (strb),
    .irqQ      (irqPulse)
  );

  capirq_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .flagsQ     (flagsQ),
    .statusWord (status)
  );

endmodule

// File: tb/test_capture_irq_flags.sv
`timescale 1ns/1ps
module test_capture_irq_flags;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        riseEvt = 0, fallEvt = 0, wrapEvt = 0;
  logic [2:0]  intEnable = '0;
  logic        clrWrEn = 0, forceWrEn = 0;
  logic [15:0] wrData = '0;
  logic        softReset = 0;
  logic [15:0] status;
  logic        irqPulse;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk; // 250 MHz

  capture_irq_flags i_capture_irq_flags (
    .clk(clk), .rstN(rstN), .riseEvt(riseEvt), .fallEvt(fallEvt),
    .wrapEvt(wrapEvt), .intEnable(intEnable), .clrWrEn(clrWrEn),
    .forceWrEn(forceWrEn), .wrData(wrData), .softReset(softReset),
    .status(status), .irqPulse(irqPulse)
  );

  // Advance one edge; sample and drive 1 ns after it.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    riseEvt = 0; fallEvt = 0; wrapEvt = 0;
    clrWrEn = 0; forceWrEn = 0; wrData = '0; softReset = 0;
  endtask

  task automatic wipe();
    softReset = 1; cyc(); softReset = 0;
  endtask

  task automatic writeClr(logic [15:0] d);
    clrWrEn = 1; wrData = d; cyc(); clrWrEn = 0; wrData = '0;
  endtask

  task automatic writeForce(logic [15:0] d);
    forceWrEn = 1; wrData = d; cyc(); forceWrEn = 0; wrData = '0;
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // R2: reset state
    cyc(); cyc();
    check("R2 status in reset", status, 16'h0);
    check("R2 irq in reset", irqPulse, 0);
    rstN = 1; cyc();
    check("R2 status after reset", status, 16'h0);

    // R3/R8/R9 sweep: every enable mask against every event combination
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        logic trig;
        wipe();
        check("R7 wipe before sweep", status, 16'h0);
        intEnable = en[2:0];
        riseEvt = ev[0]; fallEvt = ev[1]; wrapEvt = ev[2];
        cyc(); idle();
        check("R3 event flags", status, 32'(ev) << 1);
        check("R8 no irq before global", irqPulse, 0);
        trig = |(en[2:0] & ev[2:0]);
        cyc();
        check("R8 global flag", status[0], trig);
        check("R8 irq pulse", irqPulse, trig);
        check("R1 status layout", status, (32'(ev) << 1) | 32'(trig));
        cyc();
        check("R8 irq single cycle", irqPulse, 0);
      end
    end

    // R4: rising overflow
    intEnable = '0; wipe();
    riseEvt = 1; cyc(); cyc(); idle();
    check("R4 second rise sets overflow", status, 16'h0012);
    wipe();
    fallEvt = 1; cyc(); cyc(); idle();
    check("R4 repeated fall no overflow", status, 16'h0004);
    wipe();
    riseEvt = 1; cyc(); idle();
    check("R4 single rise no overflow", status, 16'h0002);
    writeForce(16'h0002);
    check("R4 forced rise sets overflow", status, 16'h0012);

    // R6: force register
    wipe();
    writeForce(16'hFFFF);
    check("R6 force all bits", status, 16'h000E);
    wipe();
    writeForce(16'h0011);
    check("R6 force bits 0 and 4 ignored", status, 16'h0000);
    writeForce(16'h0004);
    check("R6 force fall", status, 16'h0004);
    writeForce(16'h0008);
    check("R6 force wrap", status, 16'h000C);

    // R5: clear register
    wipe();
    writeForce(16'h000E);
    writeClr(16'h0004);
    check("R5 clear fall", status, 16'h000A);
    clrWrEn = 1; wrData = 16'h0002; riseEvt = 1; cyc(); idle();
    check("R5 set beats clear", status, 16'h001A);
    writeClr(16'h0010);
    check("R5 clear overflow", status, 16'h000A);
    writeClr(16'h0000);
    check("R5 zero clear no effect", status, 16'h000A);
    wrData = 16'hFFFF; cyc(); idle();
    check("R5 data without strobe", status, 16'h000A);
    writeClr(16'hFFFF);
    check("R5 clear all", status, 16'h0000);

    // R9/R10: held global flag and re-arm
    intEnable = 3'b111; wipe();
    riseEvt = 1; cyc(); idle();
    cyc();
    check("R8 irq on rise", irqPulse, 1);
    fallEvt = 1; cyc(); idle();
    check("R9 no irq while global", irqPulse, 0);
    wrapEvt = 1; cyc(); idle();
    check("R9 no irq while global 2", irqPulse, 0);
    cyc();
    check("R9 flags held", status, 16'h000F);
    check("R9 still no irq", irqPulse, 0);
    writeClr(16'h0001);
    check("R10 global cleared", status[0], 0);
    check("R10 no irq on clear edge", irqPulse, 0);
    cyc();
    check("R10 re-arm irq", irqPulse, 1);
    check("R10 re-arm global", status[0], 1);
    writeClr(16'h001F);
    check("R5 clear everything", status, 16'h0000);
    cyc();
    check("R10 no re-arm when empty", irqPulse, 0);

    // R8: masked flag never raises global
    intEnable = 3'b001; wipe();
    fallEvt = 1; cyc(); idle();
    cyc(); cyc();
    check("R8 masked fall no global", status, 16'h0004);
    check("R8 masked fall no irq", irqPulse, 0);

    // R7: soft reset over a pending set, with global held
    intEnable = 3'b111; wipe();
    riseEvt = 1; cyc(); idle(); cyc();
    check("R7 setup global", status[0], 1);
    softReset = 1; riseEvt = 1; wrapEvt = 1; cyc(); idle();
    check("R7 wipe beats set", status, 16'h0000);
    check("R7 no irq", irqPulse, 0);
    cyc();
    check("R7 still clear", status, 16'h0000);
    check("R7 no later irq", irqPulse, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule